// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Alarm

This peripheral keeps time as a plain count of seconds in a 32-bit register. It sits on a simple 32-bit register bus with an APB-style two-phase access (select, then enable). A single-cycle `tick` pulse, produced elsewhere from a slow reference clock, advances the count by one when counting is enabled. Software can read the live count and preload it through a separate load register.

A match register holds an alarm time. The raw alarm flag sets on the tick that makes the count equal to the match value. It stays set until software writes a one to the clear register. A mask bit gates the raw flag onto the masked status register and onto the level interrupt output `irq`.

Register word offsets: 0x00 count (read only), 0x04 match (read/write), 0x08 load (write only), 0x0C control (bit 0 enables counting), 0x10 mask (bit 0), 0x14 raw status (bit 0, read only), 0x18 masked status (bit 0, read only), 0x1C clear (bit 0, write only).

Top module: `secs_rtc`

## Requirements
- R1: After reset the count, match, control, mask, raw status and masked status all read 0, and `irq` is low.
- R2: With control bit 0 set, each `tick` adds one to the count at offset 0x00. With control bit 0 clear, a tick leaves the count unchanged.
- R3: A write to offset 0x08 replaces the count on the next clock edge. Loading a value equal to the match value does not set the raw alarm.
- R4: A tick taken at count 0xFFFFFFFF gives count 0. If match is 0, that same tick sets the raw alarm.
- R5: Raw status bit 0 (offset 0x14) sets on the tick where the count becomes equal to the match value at offset 0x04. It stays set while further ticks move the count past the match value.
- R6: Writing 1 to bit 0 of offset 0x1C clears the raw alarm. Writing 0 there leaves the raw alarm unchanged.
- R7: Masked status bit 0 (offset 0x18) equals raw bit 0 AND mask bit 0 (offset 0x10), and `irq` follows that masked bit.
- R8: The raw alarm sets whether or not the mask bit is set.
- R9: Reads of offsets 0x08, 0x1C and 0x20 to 0x3C return 0.
- R10: When a clear write and an alarm-setting tick fall in the same cycle, the raw alarm ends up set.
- R11: The match register reads back all 32 written bits. Control and mask keep only bit 0, and their other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse, once per second |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W (6) | Byte address; bits [ADDR_W-1:2] pick the word |
| pwdata | input | DATA_W (32) | Write data |
| prdata | output | DATA_W (32) | Read data, combinational from paddr |
| irq | output | 1 | Level interrupt, masked alarm |

## Verification
The hardest cases to reach from the ports are the ones where two events land on the same clock edge. The first is a clear write arriving in the same cycle as the tick that reaches the match value. The second is the alarm firing across the wrap from 0xFFFFFFFF to 0. The bench stretches a tick over the access phase of the clear write so that both act on one edge. It reaches the wrap by preloading the count just below the top. It then sweeps the distance between the preload and the match value, so the alarm is seen one tick early, exactly on time, and after the count has moved past.

// File: rtl/secs_rtc.sv
module secs_rtc #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] IX_COUNT  = IDX_W'(0);
  localparam logic [IDX_W-1:0] IX_MATCH  = IDX_W'(1);
  localparam logic [IDX_W-1:0] IX_LOAD   = IDX_W'(2);
  localparam logic [IDX_W-1:0] IX_CTRL   = IDX_W'(3);
  localparam logic [IDX_W-1:0] IX_MASK   = IDX_W'(4);
  localparam logic [IDX_W-1:0] IX_RAW    = IDX_W'(5);
  localparam logic [IDX_W-1:0] IX_MASKED = IDX_W'(6);
  localparam logic [IDX_W-1:0] IX_CLEAR  = IDX_W'(7);

  logic [DATA_W-1:0] cnt_q, match_q;
  logic              en_q, mask_q, raw_q;
  logic [IDX_W-1:0]  idx;
  logic              wr, load_wr, clr_wr, hit;
  logic [1:0]        unused_lsb;

  assign idx        = paddr[ADDR_W-1:2];
  assign unused_lsb = paddr[1:0];
  assign wr         = psel & penable & pwrite;
  assign load_wr    = wr && (idx == IX_LOAD);
  assign clr_wr     = wr && (idx == IX_CLEAR) && pwdata[0];
  assign hit        = tick && en_q && !load_wr && ((cnt_q + DATA_W'(1)) == match_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_wr) begin
      cnt_q <= pwdata;
    end else if (tick && en_q) begin
      cnt_q <= cnt_q + DATA_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q <= '0;
      en_q    <= 1'b0;
      mask_q  <= 1'b0;
    end else if (wr) begin
      if (idx == IX_MATCH) match_q <= pwdata;
      if (idx == IX_CTRL)  en_q    <= pwdata[0];
      if (idx == IX_MASK)  mask_q  <= pwdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      raw_q <= 1'b0;
    else if (hit)    raw_q <= 1'b1;
    else if (clr_wr) raw_q <= 1'b0;
  end

  assign irq = raw_q & mask_q;

  always_comb begin
    prdata = '0;
    case (idx)
      IX_COUNT:  prdata = cnt_q;
      IX_MATCH:  prdata = match_q;
      IX_CTRL:   prdata[0] = en_q;
      IX_MASK:   prdata[0] = mask_q;
      IX_RAW:    prdata[0] = raw_q;
      IX_MASKED: prdata[0] = irq;
      default:   prdata = '0;
    endcase
  end
endmodule

// File: rtl/secs_rtc_chk.sv
module secs_rtc_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic              irq,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] match,
  input logic              en,
  input logic              mask,
  input logic              raw
);
  logic do_load, do_clr, step;
  assign do_load = psel && penable && pwrite && (paddr[ADDR_W-1:2] == (ADDR_W-2)'(2));
  assign do_clr  = psel && penable && pwrite && (paddr[ADDR_W-1:2] == (ADDR_W-2)'(7)) && pwdata[0];
  assign step    = tick && en && !do_load;

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!do_load && !(tick && en)) |=> $stable(cnt));
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt == $past(cnt) + DATA_W'(1)));
  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> (cnt == $past(pwdata)));
  assert_raw_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ((cnt + DATA_W'(1)) == match)) |=> raw);
  assert_raw_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (raw && !do_clr) |=> raw);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (do_clr && !(step && ((cnt + DATA_W'(1)) == match))) |=> !raw);
  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (raw && mask));
endmodule

bind secs_rtc secs_rtc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .psel(psel), .penable(penable),
  .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .irq(irq),
  .cnt(cnt_q), .match(match_q), .en(en_q), .mask(mask_q), .raw(raw_q)
);

// File: tb/secs_rtc_tb_top.sv
module secs_rtc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [5:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  secs_rtc dut_i (.clk(clk), .rst_n(rst_n), .tick(tick), .psel(psel),
    .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic with_tick);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1; tick = with_tick;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0; tick = 0;
  endtask

  task automatic rdreg(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1;
    #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rdreg(6'(a * 4), rd); chk("R1 reset read", rd, 0);
    end
    #1 chk("R1 irq after reset", {31'b0, irq}, 0);

    // R11 read-back widths
    wr(6'h04, 32'hA5A5_1234, 0); rdreg(6'h04, rd); chk("R11 match", rd, 32'hA5A5_1234);
    wr(6'h0C, 32'hFFFF_FFFF, 0); rdreg(6'h0C, rd); chk("R11 ctrl", rd, 1);
    wr(6'h10, 32'hFFFF_FFFE, 0); rdreg(6'h10, rd); chk("R11 mask", rd, 0);
    wr(6'h10, 32'hFFFF_FFFF, 0); rdreg(6'h10, rd); chk("R11 mask set", rd, 1);
    wr(6'h10, 0, 0); wr(6'h0C, 0, 0);

    // R9 write-only and unmapped offsets
    wr(6'h08, 32'h1234_5678, 0);
    rdreg(6'h08, rd); chk("R9 load reads 0", rd, 0);
    rdreg(6'h1C, rd); chk("R9 clear reads 0", rd, 0);
    for (int a = 8; a < 16; a++) begin
      rdreg(6'(a * 4), rd); chk("R9 unmapped", rd, 0);
    end

    // R2 / R3 enable gating and load
    wr(6'h08, 100, 0); rdreg(6'h00, rd); chk("R3 load", rd, 100);
    tk(3); rdreg(6'h00, rd); chk("R2 disabled hold", rd, 100);
    wr(6'h0C, 1, 0);
    for (int n = 1; n <= 5; n++) begin
      tk(1); rdreg(6'h00, rd); chk("R2 step", rd, 32'(100 + n));
    end
    wr(6'h04, 700, 0); wr(6'h08, 700, 0);
    rdreg(6'h14, rd); chk("R3 load to match no alarm", rd, 0);

    // R5 / R6 / R8 sweep of distance to match, mask off
    for (int k = 1; k <= 4; k++) begin
      wr(6'h1C, 1, 0);
      wr(6'h08, 32'(1000 * k), 0);
      wr(6'h04, 32'(1000 * k + k), 0);
      tk(k - 1); rdreg(6'h14, rd); chk("R5 before match", rd, 0);
      tk(1); rdreg(6'h14, rd); chk("R5 on match", rd, 1);
      chk("R8 irq masked off", {31'b0, irq}, 0);
      tk(2); rdreg(6'h14, rd); chk("R5 sticky past match", rd, 1);
      rdreg(6'h00, rd); chk("R2 count past match", rd, 32'(1000 * k + k + 2));
      wr(6'h1C, 0, 0); rdreg(6'h14, rd); chk("R6 write 0 no effect", rd, 1);
      wr(6'h1C, 1, 0); rdreg(6'h14, rd); chk("R6 clear", rd, 0);
    end

    // R7 masking
    wr(6'h08, 20, 0); wr(6'h04, 21, 0); tk(1);
    rdreg(6'h18, rd); chk("R7 masked off", rd, 0);
    wr(6'h10, 1, 0);
    rdreg(6'h18, rd); chk("R7 masked on", rd, 1);
    chk("R7 irq on", {31'b0, irq}, 1);
    wr(6'h10, 0, 0); #1 chk("R7 irq off by mask", {31'b0, irq}, 0);
    wr(6'h10, 1, 0); wr(6'h1C, 1, 0);
    #1 chk("R7 irq off by clear", {31'b0, irq}, 0);
    rdreg(6'h18, rd); chk("R7 masked after clear", rd, 0);

    // R4 wrap
    wr(6'h08, 32'hFFFF_FFFE, 0); wr(6'h04, 0, 0);
    tk(1); rdreg(6'h00, rd); chk("R4 top", rd, 32'hFFFF_FFFF);
    rdreg(6'h14, rd); chk("R4 no alarm yet", rd, 0);
    tk(1); rdreg(6'h00, rd); chk("R4 wrap", rd, 0);
    rdreg(6'h14, rd); chk("R4 alarm at wrap", rd, 1);
    chk("R4 irq at wrap", {31'b0, irq}, 1);

    // R10 set beats clear
    wr(6'h1C, 1, 0);
    wr(6'h08, 50, 0); wr(6'h04, 51, 0);
    wr(6'h1C, 1, 1);
    rdreg(6'h14, rd); chk("R10 set wins", rd, 1);
    rdreg(6'h00, rd); chk("R10 count advanced", rd, 51);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule